// File: doc/BRIEF.md
# Serial CRC Link Checker

This block models one protected serial transfer between a sending side and a receiving side inside a single module. The sender shifts a message out one bit per clock over a one-bit channel that carries a valid strobe. Both sides run their own four-bit CRC divider on the bits as they pass. On every bit, a divider shifts its register left, takes the incoming bit into the low end, and XORs in the generator whenever the bit shifted out of the top was one. Once the message is through, both dividers take four zero bits to finish the division. The sender's remainder then travels over the same channel, and the receiver decides whether the transfer was clean.

Two check modes are offered. In compare mode the receiver collects the four remainder bits and compares them with its own finished remainder. In append mode the receiver treats the remainder as the tail of the message. It saves its divider state at the end of the message and, when the remainder bits arrive, continues from that saved state. This works as if the remainder had stood in the padding from the start, and a clean transfer leaves a zero syndrome. An error-injection input inverts the channel bit on any cycle where it is high and the channel is valid. This is how the detection of single-bit channel errors is exercised.

Top module: `crc_link_checker`

## Requirements
- R1: While reset is applied and after it is released with no start, `done`, `ok`, `err` and `ser_vld` are all 0.
- R2: A `start` seen when idle latches `msg` and `mode`. For the next MSG_W cycles `ser_vld` is 1 and `ser_bit` carries the message, most significant bit first. After a transfer with no injected error, `rx_msg` equals `msg`.
- R3: After the message, `ser_vld` is 0 for four cycles while both dividers take zero bits. The resulting remainder is the remainder of msg·x^4 divided by x^4+x^3+1 (generator 1001). For message 10101101 it is 1001.
- R4: The four remainder bits then follow on `ser_bit` with `ser_vld` high, most significant bit first. `done` is high for exactly one cycle, MSG_W+8 clock edges after the edge that sampled `start`.
- R5: With `mode`=0 (compare), a clean transfer gives `ok`=1 when the received remainder equals the receiver's own remainder.
- R6: With `mode`=1 (append), the receiver continues from the divider state it saved at the end of the message. It reports `ok`=1 exactly when its divider reads 0000 after the four received remainder bits.
- R7: `flip`=1 during a cycle with `ser_vld`=1 inverts the bit the receiver takes in that cycle. A single inverted bit, anywhere in the message or the remainder, gives `err`=1 in both modes.
- R8: Exactly one of `ok` and `err` is 1 together with `done`. That value holds until the next accepted `start`, which clears both.
- R9: A `start` while a transfer is in progress is ignored: the timing and the outcome of the running transfer do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| mode | input | 1 | 0 compare mode, 1 append mode |
| msg | input | MSG_W | Message to send |
| flip | input | 1 | Invert the channel bit this cycle |
| ser_bit | output | 1 | Channel bit as the receiver sees it |
| ser_vld | output | 1 | Channel bit is valid |
| rx_msg | output | MSG_W | Message assembled by the receiver |
| done | output | 1 | One-cycle end-of-transfer pulse |
| ok | output | 1 | Last transfer judged clean |
| err | output | 1 | Last transfer judged corrupted |

## Verification
Random messages are sent in both modes, both clean and with one inverted channel bit at a random message or remainder position. Clean runs show whether the two dividers stay in lockstep. Runs with an error in the message and runs with an error in the remainder tell apart a divider fault from a fault in the exchange or the snapshot path. The message 10101101 is sent as a fixed case so that the remainder seen on the channel must be 1001. A start pulsed in the middle of a transfer shows that a busy transfer ignores it.

// File: rtl/crc_link_checker.sv
module crc_link_checker #(
  parameter int MSG_W = 8,
  parameter int CRC_W = 4,
  parameter logic [CRC_W-1:0] GEN = 4'b1001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [MSG_W-1:0] msg,
  input  logic             flip,
  output logic             ser_bit,
  output logic             ser_vld,
  output logic [MSG_W-1:0] rx_msg,
  output logic             done,
  output logic             ok,
  output logic             err
);
  localparam int CNT_W = $clog2(MSG_W + CRC_W);

  typedef enum logic [1:0] {IDLE, SEND, FLUSH, XCHG} st_t;

  st_t              state;
  logic [CNT_W-1:0] cnt;
  logic             mode_q;
  logic [MSG_W-1:0] tx_sh;
  logic [CRC_W-1:0] tx_crc, rx_crc, snap, rx_rcv, rx_next, rx_base;
  logic             pass, last_bit;

  function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] c, input logic b);
    return {c[CRC_W-2:0], b} ^ (c[CRC_W-1] ? GEN : '0);
  endfunction

  assign ser_vld  = (state == SEND) || (state == XCHG);
  assign ser_bit  = ((state == SEND) ? tx_sh[MSG_W-1] : tx_crc[CRC_W-1]) ^ (flip & ser_vld);
  assign rx_base  = (mode_q && cnt == '0) ? snap : rx_crc;
  assign rx_next  = step(rx_base, ser_bit);
  assign pass     = mode_q ? (rx_next == '0) : ({rx_rcv[CRC_W-2:0], ser_bit} == rx_crc);
  assign last_bit = (cnt == CNT_W'(CRC_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= IDLE;
      cnt    <= '0;
      mode_q <= 1'b0;
      tx_sh  <= '0;
      tx_crc <= '0;
      rx_crc <= '0;
      snap   <= '0;
      rx_rcv <= '0;
      rx_msg <= '0;
      done   <= 1'b0;
      ok     <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (start) begin
          tx_sh  <= msg;
          tx_crc <= '0;
          rx_crc <= '0;
          rx_rcv <= '0;
          rx_msg <= '0;
          mode_q <= mode;
          cnt    <= '0;
          ok     <= 1'b0;
          err    <= 1'b0;
          state  <= SEND;
        end
        SEND: begin
          tx_sh  <= tx_sh << 1;
          tx_crc <= step(tx_crc, tx_sh[MSG_W-1]);
          rx_crc <= step(rx_crc, ser_bit);
          rx_msg <= {rx_msg[MSG_W-2:0], ser_bit};
          if (cnt == CNT_W'(MSG_W - 1)) begin
            cnt   <= '0;
            state <= FLUSH;
          end else cnt <= cnt + 1'b1;
        end
        FLUSH: begin
          if (cnt == '0) snap <= rx_crc;
          tx_crc <= step(tx_crc, 1'b0);
          rx_crc <= step(rx_crc, 1'b0);
          if (last_bit) begin
            cnt   <= '0;
            state <= XCHG;
          end else cnt <= cnt + 1'b1;
        end
        XCHG: begin
          tx_crc <= tx_crc << 1;
          rx_rcv <= {rx_rcv[CRC_W-2:0], ser_bit};
          if (mode_q) rx_crc <= rx_next;
          if (last_bit) begin
            done  <= 1'b1;
            ok    <= pass;
            err   <= !pass;
            cnt   <= '0;
            state <= IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  AST_RESULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) done |-> (ok ^ err)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (state == IDLE && start) |=> (!ok && !err && !done)); // R8
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(state == IDLE && start) && !(state == XCHG && last_bit) |=> ($stable(ok) && $stable(err))); // R8
  AST_NO_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(ok && err)); // R8
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEND && cnt != '0) |-> $stable(mode_q)); // R9
  AST_SNAP_END_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XCHG && cnt == '0) |-> (snap == $past(rx_crc, CRC_W))); // R6
endmodule

// File: tb/crc_link_checker_tb.sv
module crc_link_checker_tb;
  localparam int MSG_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0, flip = 1'b0;
  logic [MSG_W-1:0] msg = '0;
  logic ser_bit, ser_vld, done, ok, err;
  logic [MSG_W-1:0] rx_msg;

  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  crc_link_checker #(.MSG_W(MSG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .msg(msg), .flip(flip),
    .ser_bit(ser_bit), .ser_vld(ser_vld), .rx_msg(rx_msg),
    .done(done), .ok(ok), .err(err)
  );

  function automatic logic [3:0] ref_crc(input logic [7:0] m);
    logic [11:0] r;
    r = {m, 4'b0000};
    for (int i = 11; i >= 4; i--)
      if (r[i]) r = r ^ (12'b11001 << (i - 4));
    return r[3:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] m, input logic md, input int fk, input int bk);
    logic [15:0] exp_vld, got_vld, exp_bit, got_bit;
    logic [3:0] c;
    logic [7:0] exp_rx;
    c = ref_crc(m);
    @(negedge clk);
    msg = m; mode = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 16; k++) begin
      flip = (k == fk);
      start = (k == bk);
      #1;
      exp_vld[k] = (k < 8) || (k >= 12);
      exp_bit[k] = (k < 8) ? m[7-k] : ((k >= 12) ? c[15-k] : 1'b0);
      if (k == fk) exp_bit[k] = ~exp_bit[k];
      got_vld[k] = ser_vld;
      got_bit[k] = ser_vld ? ser_bit : 1'b0;
      check("R4 done early", done, 1'b0);
      @(negedge clk);
    end
    flip = 1'b0; start = 1'b0;
    check("R2/R3 valid strobe", got_vld, exp_vld);
    check("R7 channel stream", got_bit, exp_bit);
    check("R4 done timing", done, 1'b1);
    if (fk < 0) check(md ? "R6 clean append ok" : "R5 clean compare ok", {ok, err}, 2'b10);
    else        check("R7 single flip err", {ok, err}, 2'b01);
    exp_rx = m;
    if (fk >= 0 && fk < 8) exp_rx[7-fk] = ~exp_rx[7-fk];
    check("R2 rx_msg", rx_msg, exp_rx);
    @(negedge clk);
    check("R4 done one cycle", done, 1'b0);
    check("R8 result held", {ok, err}, (fk < 0) ? 2'b10 : 2'b01);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        errors++;
        $display("FAIL watchdog actual %0d expected <50000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {done, ok, err, ser_vld}, 4'b0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle outputs", {done, ok, err, ser_vld}, 4'b0000);

    check("R3 remainder of 10101101", ref_crc(8'b10101101), 4'b1001);
    run(8'b10101101, 1'b1, -1, -1);
    run(8'b10101101, 1'b0, -1, -1);
    run(8'b10101101, 1'b1, 3, -1);
    run(8'b10101101, 1'b0, 13, -1);
    run(8'h00, 1'b1, -1, -1);
    run(8'hFF, 1'b0, 15, -1);
    run(8'h5A, 1'b0, -1, 5);
    run(8'h5A, 1'b1, 0, 13);

    for (int n = 0; n < 60; n++) begin
      logic [7:0] m;
      logic md;
      int fk, p;
      m = 8'($urandom);
      md = 1'($urandom);
      fk = -1;
      if ($urandom % 2) begin
        p = int'($urandom % 12);
        fk = (p < 8) ? p : p + 4;
      end
      run(m, md, fk, -1);
    end

    @(negedge clk);
    msg = 8'h33; mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 start clears result", {ok, err}, 2'b00);
    repeat (20) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule